// File: doc/BRIEF.md
# Tamper monitor security state controller

This block holds the security state of a battery-backed tamper monitor. Ten event lines enter it: voltage, clock, temperature, secure-controller alarm, external boot, external tamper A, external tamper B, wire mesh, time counter overflow and monotonic counter overflow. Each line passes through a synchronizer and is masked by its bit in a tamper configuration register. An event that is enabled latches its own status bit and raises the violation flag. The violation flag drives a freeze output that halts the time and monotonic counters, so the moment of the violation is kept.

The state is carried by two flags, non-valid and violation, read together as `sec_state = {violation, non_valid}`. Software leaves a failure in stages. It clears the latched causes. It then clears the violation flag, which succeeds only once no enabled cause is still latched. It clears the non-valid flag last. Some lock bits are soft and a system reset clears them. Others are hard and only a battery-domain reset clears them. Once the configuration locks are set, the tamper setup can no longer be changed. The failure-state hard lock keeps a failed unit from being moved into the recoverable state.

The battery-domain reset `bat_rst_n` is asserted asynchronously and released through a synchronizer. The system reset arrives as the one-cycle request `sys_rst_pulse`. Register writes take one cycle each. Reads come combinationally from the register state.

Top module: `tmon_secstate`

## Requirements
- R1: The battery reset is asserted asynchronously and takes effect on the third rising edge after `bat_rst_n` goes high. It leaves the status register (address 1) reading 0x00000002: non-valid is set and everything else is clear. The control register (address 0), the tamper configuration register (address 2) and the interrupt-enable register (address 3) all read zero.
- R2: `sec_state` is {violation, non_valid}. 00 means valid, 01 means non-valid, 10 means failure and 11 means recoverable failure. Status bit 0 is violation and status bit 1 is non-valid.
- R3: Source index i is enabled by configuration bit i. The sources are 0 voltage, 1 clock, 2 temperature, 3 secure alarm, 4 external boot, 5 external A, 6 external B, 7 wire mesh, 8 time overflow and 9 monotonic overflow. When an enabled source is high, it sets its status bit (16+i for i<8, bit 2 for source 8, bit 3 for source 9) and the violation flag. Both show SYNC_STAGES+1 rising edges after the input rises. A source whose enable bit is clear is ignored.
- R4: `freeze` equals the violation flag. `sv_irq` is high exactly when the violation flag and interrupt-enable bit 0 are both set.
- R5: Writing a one to an event status bit clears it, and writing a zero has no effect. A detection in the same cycle as the clear wins, and the bit stays set.
- R6: Writing a one to status bit 0 clears the violation flag only if, before that write, no latched event bit has its source enabled, and no enabled detection arrives in the same cycle.
- R7: Writing a one to status bit 1 clears the non-valid flag only while the violation flag is clear.
- R8: A write to the tamper configuration register is ignored while control bit 30 (hard lock) or control bit 29 (soft lock) is set.
- R9: Control bits 30, 29 and 16 (failure-state hard lock) can only be set from the bus. A written zero leaves them unchanged.
- R10: A system reset clears control bit 29 and leaves bits 30 and 16 as they are.
- R11: A system reset in failure (10) moves the unit to 11 when control bit 16 is clear and leaves it in 10 when bit 16 is set. In any other state it leaves the flags unchanged.
- R12: A bus write in the same cycle as a system reset is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| bat_rst_n | input | 1 | Battery-domain reset, active low |
| sys_rst_pulse | input | 1 | One-cycle system reset request |
| evt_raw | input | 10 | Raw event lines, index per R3 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 status, 2 config, 3 irq enable) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data of register at rd_addr |
| freeze | output | 1 | Counter stop, high while violation is set |
| sv_irq | output | 1 | Security-violation interrupt |
| sec_state | output | 2 | {violation, non_valid} |

## Verification
A register write or a system reset shows on `rd_data`, `sec_state`, `freeze` and `sv_irq` right after the rising edge that captures it, because reads are combinational from state. A rising event line shows SYNC_STAGES+1 edges later, because of the synchronizer and the latch. The bench changes inputs just after a falling edge and compares all outputs against its reference model at every falling edge. Its directed checks read a chosen register half a cycle or more after the edge that is due to update it, and the event-latency check samples the edge before the update and the edge of the update.

// File: rtl/tmon_pkg.sv
package tmon_pkg;

  localparam int N_SRC   = 10;
  localparam int N_SENSE = 8;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 2;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_CFG  = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_IEN  = 2'd3;

  localparam int BIT_SV      = 0;
  localparam int BIT_NV      = 1;
  localparam int BIT_TOVF    = 2;
  localparam int BIT_SENSE0  = 16;
  localparam int BIT_FAIL_HL = 16;
  localparam int BIT_CFG_SL  = 29;
  localparam int BIT_CFG_HL  = 30;
  localparam int BIT_SVIE    = 0;

  typedef enum logic [1:0] {
    ST_VALID    = 2'b00,
    ST_NONVALID = 2'b01,
    ST_FAILURE  = 2'b10,
    ST_RECOVER  = 2'b11
  } sec_state_e;

  function automatic int stat_pos(int idx);
    if (idx < N_SENSE) return BIT_SENSE0 + idx;
    else               return BIT_TOVF + (idx - N_SENSE);
  endfunction

endpackage

// File: rtl/tmon_rst_sync.sv
module tmon_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/tmon_evt_sync.sv
module tmon_evt_sync #(
  parameter int WIDTH  = 10,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] sync_o
);

  generate
    if (STAGES == 1) begin : g_single
      logic [WIDTH-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= raw_i;
      end
      assign sync_o = q;
    end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] pipe_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[STAGES-2:0], raw_i};
      end
      assign sync_o = pipe_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/tmon_evt_latch.sv
module tmon_evt_latch #(
  parameter int WIDTH = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] evt_o
);

  logic [WIDTH-1:0] evt_q;
  logic [WIDTH-1:0] evt_n;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      always_comb begin
        evt_n[i] = evt_q[i];
        if (clr_i[i]) evt_n[i] = 1'b0;
        if (set_i[i]) evt_n[i] = 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt_q[i] <= 1'b0;
        else        evt_q[i] <= evt_n[i];
      end

      // R5: a detection in the clearing cycle keeps the bit set
      a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[i] |=> evt_o[i]);
    end
  endgenerate

  assign evt_o = evt_q;

endmodule

// File: rtl/tmon_ctrl_regs.sv
module tmon_ctrl_regs #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sys_rst_i,
  input  logic         wr_ctrl_i,
  input  logic         wr_cfg_i,
  input  logic         wr_ien_i,
  input  logic         set_cfg_hl_i,
  input  logic         set_cfg_sl_i,
  input  logic         set_fail_hl_i,
  input  logic [N-1:0] cfg_d_i,
  input  logic         ien_d_i,
  output logic [N-1:0] cfg_o,
  output logic         cfg_hl_o,
  output logic         cfg_sl_o,
  output logic         fail_hl_o,
  output logic         irq_en_o
);

  logic [N-1:0] cfg_q, cfg_n;
  logic         cfg_hl_q, cfg_hl_n;
  logic         cfg_sl_q, cfg_sl_n;
  logic         fail_hl_q, fail_hl_n;
  logic         ien_q, ien_n;
  logic         cfg_we;

  assign cfg_we = wr_cfg_i && !cfg_hl_q && !cfg_sl_q;

  always_comb begin
    cfg_n     = cfg_q;
    cfg_hl_n  = cfg_hl_q;
    cfg_sl_n  = cfg_sl_q;
    fail_hl_n = fail_hl_q;
    ien_n     = ien_q;
    if (cfg_we) cfg_n = cfg_d_i;
    if (wr_ctrl_i) begin
      cfg_hl_n  = cfg_hl_q  | set_cfg_hl_i;
      cfg_sl_n  = cfg_sl_q  | set_cfg_sl_i;
      fail_hl_n = fail_hl_q | set_fail_hl_i;
    end
    if (sys_rst_i) cfg_sl_n = 1'b0;
    if (wr_ien_i) ien_n = ien_d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      cfg_hl_q  <= 1'b0;
      cfg_sl_q  <= 1'b0;
      fail_hl_q <= 1'b0;
      ien_q     <= 1'b0;
    end else begin
      cfg_q     <= cfg_n;
      cfg_hl_q  <= cfg_hl_n;
      cfg_sl_q  <= cfg_sl_n;
      fail_hl_q <= fail_hl_n;
      ien_q     <= ien_n;
    end
  end

  assign cfg_o     = cfg_q;
  assign cfg_hl_o  = cfg_hl_q;
  assign cfg_sl_o  = cfg_sl_q;
  assign fail_hl_o = fail_hl_q;
  assign irq_en_o  = ien_q;

  a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_hl_q || cfg_sl_q) |=> $stable(cfg_q));

  a_r9_cfg_hl_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_hl_q |=> cfg_hl_q);

  a_r10_fail_hl_survives: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_hl_q && sys_rst_i) |=> fail_hl_q);

  a_r10_soft_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_i |=> !cfg_sl_q);

endmodule

// File: rtl/tmon_state_flags.sv
module tmon_state_flags
  import tmon_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sys_rst_i,
  input  logic       sv_clr_i,
  input  logic       nv_clr_i,
  input  logic       hit_any_i,
  input  logic       cause_live_i,
  input  logic       fail_hl_i,
  output sec_state_e state_o
);

  logic sv_q, sv_n;
  logic nv_q, nv_n;

  always_comb begin
    sv_n = sv_q;
    nv_n = nv_q;
    if (sys_rst_i) begin
      if (sv_q && !nv_q && !fail_hl_i) nv_n = 1'b1;
    end else begin
      if (sv_clr_i && !cause_live_i && !hit_any_i) sv_n = 1'b0;
      if (nv_clr_i && !sv_q) nv_n = 1'b0;
    end
    if (hit_any_i) sv_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sv_q <= 1'b0;
      nv_q <= 1'b1;
    end else begin
      sv_q <= sv_n;
      nv_q <= nv_n;
    end
  end

  assign state_o = sec_state_e'({sv_q, nv_q});

  a_r6_sv_held: assert property (@(posedge clk) disable iff (!rst_n)
    (sv_q && cause_live_i) |=> state_o[1]);

  a_r7_nv_order: assert property (@(posedge clk) disable iff (!rst_n)
    (sv_q && nv_q) |=> state_o[0]);

  a_r11_recover: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst_i && state_o == ST_FAILURE && !fail_hl_i) |=> state_o == ST_RECOVER);

  a_r11_hard_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst_i && state_o == ST_FAILURE && fail_hl_i) |=> state_o == ST_FAILURE);

endmodule

// File: rtl/tmon_secstate.sv
module tmon_secstate
  import tmon_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              bat_rst_n,
  input  logic              sys_rst_pulse,
  input  logic [N_SRC-1:0]  evt_raw,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              freeze,
  output logic              sv_irq,
  output logic [1:0]        sec_state
);

  logic             rst_i;
  logic [N_SRC-1:0] evt_sync;
  logic [N_SRC-1:0] cfg;
  logic [N_SRC-1:0] evt_q;
  logic [N_SRC-1:0] hit;
  logic [N_SRC-1:0] evt_clr;
  logic             cfg_hl, cfg_sl, fail_hl, irq_en;
  logic             bus_wr, wr_ctrl, wr_stat, wr_cfg, wr_ien;
  logic             sv, nv;
  sec_state_e       state;
  logic [DATA_W-1:0] stat_word;
  logic             unused_wdata;

  tmon_rst_sync #(.STAGES(RST_STAGES)) i_rst_sync (
    .clk     (clk),
    .arst_n  (bat_rst_n),
    .rst_n_o (rst_i)
  );

  tmon_evt_sync #(.WIDTH(N_SRC), .STAGES(SYNC_STAGES)) i_evt_sync (
    .clk    (clk),
    .rst_n  (rst_i),
    .raw_i  (evt_raw),
    .sync_o (evt_sync)
  );

  assign bus_wr  = wr_en && !sys_rst_pulse;
  assign wr_ctrl = bus_wr && (wr_addr == ADR_CTRL);
  assign wr_stat = bus_wr && (wr_addr == ADR_STAT);
  assign wr_cfg  = bus_wr && (wr_addr == ADR_CFG);
  assign wr_ien  = bus_wr && (wr_addr == ADR_IEN);

  assign hit = evt_sync & cfg;

  generate
    for (genvar i = 0; i < N_SRC; i++) begin : g_clr
      localparam int P = stat_pos(i);
      assign evt_clr[i] = wr_stat && wr_data[P];
    end
  endgenerate

  tmon_evt_latch #(.WIDTH(N_SRC)) i_evt_latch (
    .clk   (clk),
    .rst_n (rst_i),
    .set_i (hit),
    .clr_i (evt_clr),
    .evt_o (evt_q)
  );

  tmon_ctrl_regs #(.N(N_SRC)) i_ctrl_regs (
    .clk           (clk),
    .rst_n         (rst_i),
    .sys_rst_i     (sys_rst_pulse),
    .wr_ctrl_i     (wr_ctrl),
    .wr_cfg_i      (wr_cfg),
    .wr_ien_i      (wr_ien),
    .set_cfg_hl_i  (wr_data[BIT_CFG_HL]),
    .set_cfg_sl_i  (wr_data[BIT_CFG_SL]),
    .set_fail_hl_i (wr_data[BIT_FAIL_HL]),
    .cfg_d_i       (wr_data[N_SRC-1:0]),
    .ien_d_i       (wr_data[BIT_SVIE]),
    .cfg_o         (cfg),
    .cfg_hl_o      (cfg_hl),
    .cfg_sl_o      (cfg_sl),
    .fail_hl_o     (fail_hl),
    .irq_en_o      (irq_en)
  );

  tmon_state_flags i_state_flags (
    .clk          (clk),
    .rst_n        (rst_i),
    .sys_rst_i    (sys_rst_pulse),
    .sv_clr_i     (wr_stat && wr_data[BIT_SV]),
    .nv_clr_i     (wr_stat && wr_data[BIT_NV]),
    .hit_any_i    (|hit),
    .cause_live_i (|(evt_q & cfg)),
    .fail_hl_i    (fail_hl),
    .state_o      (state)
  );

  assign sv = state[1];
  assign nv = state[0];

  always_comb begin
    stat_word = '0;
    stat_word[BIT_SV] = sv;
    stat_word[BIT_NV] = nv;
    for (int i = 0; i < N_SRC; i++) stat_word[stat_pos(i)] = evt_q[i];
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADR_CTRL: begin
        rd_data[BIT_CFG_HL]  = cfg_hl;
        rd_data[BIT_CFG_SL]  = cfg_sl;
        rd_data[BIT_FAIL_HL] = fail_hl;
      end
      ADR_STAT: rd_data = stat_word;
      ADR_CFG:  rd_data[N_SRC-1:0] = cfg;
      default:  rd_data[BIT_SVIE] = irq_en;
    endcase
  end

  assign freeze    = sv;
  assign sv_irq    = sv && irq_en;
  assign sec_state = state;

  assign unused_wdata = ^{wr_data[31], wr_data[28:24], wr_data[15:10]};

  a_r3_enabled_hit: assert property (@(posedge clk) disable iff (!rst_i)
    (|(evt_sync & cfg)) |=> freeze);

  a_r12_write_ignored: assert property (@(posedge clk) disable iff (!rst_i)
    (sys_rst_pulse && wr_en && wr_addr == ADR_IEN) |=> $stable(irq_en));

endmodule

// File: tb/test_tmon_secstate.sv
module test_tmon_secstate;

  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 2;

  logic        clk;
  logic        bat_rst_n;
  logic        sys_rst_pulse;
  logic [9:0]  evt_raw;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [31:0] wr_data;
  logic [1:0]  rd_addr;
  logic [31:0] rd_data;
  logic        freeze;
  logic        sv_irq;
  logic [1:0]  sec_state;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  tmon_secstate #(.SYNC_STAGES(SYNC), .RST_STAGES(2)) i_tmon_secstate (
    .clk           (clk),
    .bat_rst_n     (bat_rst_n),
    .sys_rst_pulse (sys_rst_pulse),
    .evt_raw       (evt_raw),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .rd_addr       (rd_addr),
    .rd_data       (rd_data),
    .freeze        (freeze),
    .sv_irq        (sv_irq),
    .sec_state     (sec_state)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  logic [9:0] m_cfg, m_evt, m_hit;
  logic       m_hl, m_sl, m_fhl, m_ien, m_sv, m_nv, m_sv_old, m_live;
  logic [9:0] m_pipe[$];
  int         m_hold;

  function automatic logic [31:0] m_read(logic [1:0] a);
    logic [31:0] v;
    v = 32'h0;
    case (a)
      2'd0: begin v[30] = m_hl; v[29] = m_sl; v[16] = m_fhl; end
      2'd1: begin
        v[0] = m_sv; v[1] = m_nv; v[2] = m_evt[8]; v[3] = m_evt[9];
        v[23:16] = m_evt[7:0];
      end
      2'd2: v[9:0] = m_cfg;
      default: v[0] = m_ien;
    endcase
    return v;
  endfunction

  always @(posedge clk or negedge bat_rst_n) begin
    if (!bat_rst_n) begin
      m_cfg = 0; m_evt = 0; m_hl = 0; m_sl = 0; m_fhl = 0; m_ien = 0;
      m_sv = 0; m_nv = 1; m_hold = 2;
      m_pipe = {};
      for (int k = 0; k < SYNC; k++) m_pipe.push_back(10'h0);
    end else if (m_hold > 0) begin
      m_hold--;
    end else begin
      m_hit    = m_pipe[SYNC-1] & m_cfg;
      m_live   = |(m_evt & m_cfg);
      m_sv_old = m_sv;
      if (sys_rst_pulse) begin
        m_sl = 0;
        if (m_sv && !m_nv && !m_fhl) m_nv = 1;
      end else if (wr_en) begin
        case (wr_addr)
          2'd0: begin
            m_hl  = m_hl  | wr_data[30];
            m_sl  = m_sl  | wr_data[29];
            m_fhl = m_fhl | wr_data[16];
          end
          2'd1: begin
            for (int k = 0; k < 8; k++) if (wr_data[16+k]) m_evt[k] = 0;
            if (wr_data[2]) m_evt[8] = 0;
            if (wr_data[3]) m_evt[9] = 0;
            if (wr_data[0] && !m_live && m_hit == 0) m_sv = 0;
            if (wr_data[1] && !m_sv_old) m_nv = 0;
          end
          2'd2: if (!m_hl && !m_sl) m_cfg = wr_data[9:0];
          default: m_ien = wr_data[0];
        endcase
      end
      m_evt = m_evt | m_hit;
      if (m_hit != 0) m_sv = 1;
      m_pipe.push_front(evt_raw);
      void'(m_pipe.pop_back());
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (bat_rst_n) begin
      chk({cur_req, " rd_data"}, rd_data, m_read(rd_addr));
      chk({cur_req, " freeze"}, {31'h0, freeze}, {31'h0, m_sv});
      chk({cur_req, " sv_irq"}, {31'h0, sv_irq}, {31'h0, m_sv & m_ien});
      chk({cur_req, " sec_state"}, {30'h0, sec_state}, {30'h0, m_sv, m_nv});
    end
  end

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #1;
      rd_addr = rd_addr + 2'd1;
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); #1;
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); #1;
    wr_en = 0; wr_data = 0;
  endtask

  task automatic sysrst(logic with_wr, logic [1:0] a, logic [31:0] d);
    @(negedge clk); #1;
    sys_rst_pulse = 1; wr_en = with_wr; wr_addr = a; wr_data = d;
    @(negedge clk); #1;
    sys_rst_pulse = 0; wr_en = 0; wr_data = 0;
  endtask

  task automatic pulse_evt(int idx);
    @(negedge clk); #1;
    evt_raw[idx] = 1'b1;
    @(negedge clk); #1;
    evt_raw[idx] = 1'b0;
  endtask

  task automatic check_reg(logic [1:0] a, logic [31:0] exp, string tag);
    @(negedge clk); #2;
    rd_addr = a; #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic check_outs(logic [1:0] st, logic frz, logic irq, string tag);
    @(negedge clk); #2;
    chk({tag, " state"}, {30'h0, sec_state}, {30'h0, st});
    chk({tag, " freeze"}, {31'h0, freeze}, {31'h0, frz});
    chk({tag, " irq"}, {31'h0, sv_irq}, {31'h0, irq});
  endtask

  task automatic bat_reset();
    @(negedge clk); #1;
    bat_rst_n = 0;
    idle(3);
    @(negedge clk); #1;
    bat_rst_n = 1;
    idle(4);
  endtask

  initial begin
    bat_rst_n = 0; sys_rst_pulse = 0; evt_raw = 0;
    wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    idle(3);
    @(negedge clk); #1;
    bat_rst_n = 1;
    idle(4);

    cur_req = "R1";
    check_reg(2'd1, 32'h0000_0002, "R1 status after battery reset");
    check_reg(2'd0, 32'h0, "R1 control after battery reset");
    check_reg(2'd2, 32'h0, "R1 config after battery reset");
    check_reg(2'd3, 32'h0, "R1 irq enable after battery reset");
    check_outs(2'b01, 1'b0, 1'b0, "R2 non-valid after reset");

    cur_req = "R7";
    wr(2'd1, 32'h2);
    check_reg(2'd1, 32'h0, "R7 non-valid cleared");
    check_outs(2'b00, 1'b0, 1'b0, "R2 valid");

    cur_req = "R3";
    pulse_evt(0);
    idle(5);
    check_reg(2'd1, 32'h0, "R3 disabled source ignored");

    wr(2'd2, 32'h3FF);
    wr(2'd3, 32'h1);
    @(negedge clk); #1;
    evt_raw[5] = 1'b1;
    @(negedge clk); #1;
    evt_raw[5] = 1'b0;
    @(negedge clk); #2;
    chk("R3 no violation one edge early", {31'h0, freeze}, 32'h0);
    @(negedge clk); #2;
    chk("R3 violation at SYNC+1 edges", {31'h0, freeze}, 32'h1);
    check_reg(2'd1, 32'h0020_0001, "R3 external A latched");
    cur_req = "R4";
    check_outs(2'b10, 1'b1, 1'b1, "R4 failure with irq");

    cur_req = "R6";
    wr(2'd1, 32'h1);
    check_reg(2'd1, 32'h0020_0001, "R6 violation held by live cause");

    cur_req = "R5";
    wr(2'd1, 32'h0);
    check_reg(2'd1, 32'h0020_0001, "R5 zero write no effect");
    wr(2'd1, 32'h0020_0000);
    check_reg(2'd1, 32'h0000_0001, "R5 event bit cleared");
    cur_req = "R6";
    wr(2'd1, 32'h1);
    check_reg(2'd1, 32'h0, "R6 violation cleared");

    cur_req = "R5";
    @(negedge clk); #1;
    evt_raw[8] = 1'b1;
    idle(4);
    wr(2'd1, 32'h4);
    check_reg(2'd1, 32'h0000_0005, "R5 detection wins over clear");
    @(negedge clk); #1;
    evt_raw[8] = 1'b0;
    idle(4);
    cur_req = "R6";
    wr(2'd1, 32'h5);
    check_reg(2'd1, 32'h0000_0001, "R6 clear uses pre-write causes");
    wr(2'd1, 32'h1);
    check_reg(2'd1, 32'h0, "R6 violation cleared afterwards");

    cur_req = "R8";
    wr(2'd0, 32'h2000_0000);
    check_reg(2'd0, 32'h2000_0000, "R9 soft lock set");
    wr(2'd2, 32'h0);
    check_reg(2'd2, 32'h3FF, "R8 config soft locked");
    cur_req = "R9";
    wr(2'd0, 32'h0);
    check_reg(2'd0, 32'h2000_0000, "R9 zero write ignored");

    cur_req = "R10";
    sysrst(1'b0, 2'd0, 32'h0);
    check_reg(2'd0, 32'h0, "R10 soft lock cleared");
    check_reg(2'd1, 32'h0, "R11 valid unchanged by system reset");
    wr(2'd2, 32'h00F);
    check_reg(2'd2, 32'h00F, "R8 config writable when unlocked");
    cur_req = "R12";
    sysrst(1'b1, 2'd2, 32'h001);
    check_reg(2'd2, 32'h00F, "R12 write with system reset ignored");

    cur_req = "R10";
    wr(2'd0, 32'h4001_0000);
    sysrst(1'b0, 2'd0, 32'h0);
    check_reg(2'd0, 32'h4001_0000, "R10 hard locks survive");
    wr(2'd2, 32'h0);
    check_reg(2'd2, 32'h00F, "R8 config hard locked");

    cur_req = "R11";
    pulse_evt(1);
    idle(4);
    check_reg(2'd1, 32'h0002_0001, "R3 clock event latched");
    sysrst(1'b0, 2'd0, 32'h0);
    check_outs(2'b10, 1'b1, 1'b1, "R11 hard lock keeps failure");

    cur_req = "R1";
    bat_reset();
    check_reg(2'd0, 32'h0, "R1 battery reset clears hard locks");
    check_reg(2'd1, 32'h0000_0002, "R1 status after second reset");

    cur_req = "R11";
    wr(2'd1, 32'h2);
    wr(2'd2, 32'h200);
    pulse_evt(9);
    idle(4);
    check_reg(2'd1, 32'h0000_0009, "R3 monotonic overflow latched");
    check_outs(2'b10, 1'b1, 1'b0, "R4 irq masked");
    sysrst(1'b0, 2'd0, 32'h0);
    check_reg(2'd1, 32'h0000_000B, "R11 recoverable failure");
    check_outs(2'b11, 1'b1, 1'b0, "R2 recoverable state");
    cur_req = "R7";
    wr(2'd1, 32'h2);
    check_reg(2'd1, 32'h0000_000B, "R7 non-valid held while violation");
    wr(2'd1, 32'h8);
    check_reg(2'd1, 32'h0000_0003, "R5 overflow bit cleared");
    wr(2'd1, 32'h1);
    check_outs(2'b01, 1'b0, 1'b0, "R6 back to non-valid");
    wr(2'd1, 32'h2);
    check_outs(2'b00, 1'b0, 1'b0, "R7 back to valid");
    idle(4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule